// File: doc/BRIEF.md
# Clock Failure Detector with Automatic Failover

This block supervises a fast external oscillator clock from a slower, always-running reference clock. Software arms it with an enable bit. Supervision starts only once the oscillator reports that its startup time has passed. While it is armed, the block watches for activity on the monitored clock. A divide-by-two toggle in the monitored domain is carried into the reference domain through a two-flop synchronizer. If no activity is seen for a programmable number of reference cycles, the block declares a failure.

A failure starts a fixed rescue sequence. The oscillator enable is withdrawn and the timer break line receives a single pulse. A non-maskable interrupt request is latched. The system clock selection is forced to the internal RC oscillator when the system clock depended on the external oscillator, either directly or through a PLL it feeds. The PLL enable is also withdrawn when the PLL was fed by the external oscillator and drove the system clock. The forced values persist until software acknowledges each one by writing the matching control. All logic runs on the reference clock with a synchronous, active-high reset. The only exception is the toggle flop in the monitored domain.

Top module: `cfd_guard`

## Requirements
- R1: After reset, `brk_pulse` and `nmi_req` are 0 and the block is disarmed. While `det_en` is 0, a stopped monitored clock causes no break pulse and no interrupt.
- R2: The detector arms only when all three of these hold: `det_en` is 1, `osc_ready` is 1 and `osc_en` is 1. It disarms in the cycle after `osc_ready` or `osc_en` goes low. A stopped clock while disarmed produces no break pulse.
- R3: A failure is declared after `TIMEOUT_CYC` (default 8) consecutive reference cycles in which the armed detector sees no monitored activity. With the bench clock ratio, the break pulse appears between `TIMEOUT_CYC` and `TIMEOUT_CYC`+6 cycles after the clock stops. A monitored clock that keeps running never causes a failure.
- R4: On a failure, `osc_en` goes to 0 in the same cycle as the break pulse. It stays 0 until software drops `osc_en_req`.
- R5: Each failure produces exactly one break pulse of one reference cycle. No further pulse occurs until `det_en` has been taken low and the detector is armed again.
- R6: On a failure, `nmi_req` goes to 1 in the same cycle as the break pulse. It stays 1 until a cycle with `irq_clear` at 1.
- R7: The `sys_sel` encoding is 0 for the internal RC oscillator, 1 for the external oscillator, 2 for the PLL and 3 for reserved (treated as RC). On a failure with `sys_sel`=1, or with `sys_sel`=2 and `pll_src_ext`=1, `sys_sel_eff` is forced to 0 until software writes `sys_sel`=0. In all other cases `sys_sel_eff` follows `sys_sel`.
- R8: On a failure with `sys_sel`=2 and `pll_src_ext`=1, `pll_en` goes to 0 until software drops `pll_en_req`. In every other case `pll_en` follows `pll_en_req`.
- R9: When `irq_clear` is 1 in the same cycle a failure is declared, `nmi_req` is still set and is 1 during the break pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| clk_mon | input | 1 | Monitored external oscillator clock |
| det_en | input | 1 | Software enable of the detector |
| osc_ready | input | 1 | External oscillator startup completed |
| osc_en_req | input | 1 | Software request to run the external oscillator |
| pll_en_req | input | 1 | Software request to run the PLL |
| sys_sel | input | 2 | Requested system clock source (0 RC, 1 external, 2 PLL) |
| pll_src_ext | input | 1 | PLL fed by the external oscillator (with or without divider) |
| irq_clear | input | 1 | Software clear of the pending failure request |
| osc_en | output | 1 | External oscillator enable after failover masking |
| pll_en | output | 1 | PLL enable after failover masking |
| sys_sel_eff | output | 2 | System clock mux select after override |
| brk_pulse | output | 1 | One-cycle failure event to the timer break input |
| nmi_req | output | 1 | Latched non-maskable interrupt request |

## Verification
Suppose the arming state or the starvation counter is wrong. Then a break pulse is either missing or extra, and this is visible within `TIMEOUT_CYC` plus a few reference cycles of the monitored clock stopping or running. The failover latches set `osc_en`, `pll_en` and `sys_sel_eff` directly, so a wrong latch value is visible in the break pulse cycle itself. A wrong latch release is visible in the cycle after the matching software write. A pending flag that is lost or stuck shows on `nmi_req` in the cycle after a clear, or after a set that coincides with a clear.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [1:0] {
        SRC_RC  = 2'd0,
        SRC_EXT = 2'd1,
        SRC_PLL = 2'd2,
        SRC_RSV = 2'd3
    } sysclk_src_e;

    typedef enum logic [1:0] {
        ARM_OFF     = 2'd0,
        ARM_LIVE    = 2'd1,
        ARM_TRIPPED = 2'd2
    } arm_state_e;

    typedef struct packed {
        logic kill_osc;
        logic kill_pll;
        logic force_rc;
    } fail_plan_t;

    localparam int unsigned DEF_TIMEOUT = 8;
    localparam int unsigned DEF_SYNC    = 2;

    function automatic fail_plan_t plan_failover(sysclk_src_e sel, logic pll_from_ext);
        fail_plan_t p;
        p.kill_osc = 1'b1;
        p.kill_pll = (sel == SRC_PLL) && pll_from_ext;
        p.force_rc = (sel == SRC_EXT) || ((sel == SRC_PLL) && pll_from_ext);
        return p;
    endfunction

endpackage

// File: rtl/cfd_activity.sv
module cfd_activity #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic clk_mon,
    input  logic rst,
    output logic activity
);
    localparam int unsigned NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic          tog;
    logic [NS-1:0] chain;
    logic          prev;

    always_ff @(posedge clk_mon) begin
        if (rst) tog <= 1'b0;
        else     tog <= ~tog;
    end

    generate
        for (genvar i = 0; i < NS; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk_ref) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= tog;
                end
            end else begin : g_next
                always_ff @(posedge clk_ref) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_ref) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[NS-1];
    end

    assign activity = chain[NS-1] ^ prev;

endmodule

// File: rtl/cfd_starve_timer.sv
module cfd_starve_timer #(
    parameter int unsigned LIMIT = cfd_pkg::DEF_TIMEOUT
) (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic activity,
    output logic starved
);
    localparam int unsigned LIM = (LIMIT < 1) ? 1 : LIMIT;
    localparam int unsigned CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !live || activity) cnt <= '0;
        else if (cnt != LAST)         cnt <= cnt + 1'b1;
    end

    assign starved = live && !activity && (cnt == LAST);

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_reset_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
        activity |=> (cnt == '0));

endmodule

// File: rtl/cfd_arm_fsm.sv
module cfd_arm_fsm
    import cfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic det_en,
    input  logic osc_ready,
    input  logic osc_on,
    input  logic starved,
    output logic live,
    output logic fail_evt
);
    arm_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_OFF:
                if (det_en && osc_ready && osc_on) state_nx = ARM_LIVE;
            ARM_LIVE:
                if (!det_en || !osc_ready || !osc_on) state_nx = ARM_OFF;
                else if (starved)                     state_nx = ARM_TRIPPED;
            ARM_TRIPPED:
                if (!det_en) state_nx = ARM_OFF;
            default: state_nx = ARM_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ARM_OFF;
        else     state <= state_nx;
    end

    assign live     = (state == ARM_LIVE);
    assign fail_evt = live && det_en && osc_ready && osc_on && starved;

    assert_disarm_R2: assert property (@(posedge clk) disable iff (rst)
        (live && (!osc_ready || !osc_on)) |=> !live);

    assert_no_rearm_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ARM_TRIPPED && det_en) |=> (state == ARM_TRIPPED));

endmodule

// File: rtl/cfd_failover.sv
module cfd_failover
    import cfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fail_evt,
    input  logic [1:0] sys_sel,
    input  logic       pll_src_ext,
    input  logic       osc_en_req,
    input  logic       pll_en_req,
    input  logic       irq_clear,
    output logic       osc_en,
    output logic       pll_en,
    output logic [1:0] sys_sel_eff,
    output logic       brk_pulse,
    output logic       nmi_req
);
    sysclk_src_e sel;
    fail_plan_t  plan;
    fail_plan_t  held;
    logic        pend;
    logic        brk_q;

    assign sel  = sysclk_src_e'(sys_sel);
    assign plan = plan_failover(sel, pll_src_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            pend  <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            brk_q <= fail_evt;
            if (fail_evt) begin
                held.kill_osc <= 1'b1;
                held.kill_pll <= held.kill_pll | plan.kill_pll;
                held.force_rc <= held.force_rc | plan.force_rc;
                pend          <= 1'b1;
            end else begin
                if (!osc_en_req)    held.kill_osc <= 1'b0;
                if (!pll_en_req)    held.kill_pll <= 1'b0;
                if (sel == SRC_RC)  held.force_rc <= 1'b0;
                if (irq_clear)      pend          <= 1'b0;
            end
        end
    end

    assign osc_en      = osc_en_req & ~held.kill_osc;
    assign pll_en      = pll_en_req & ~held.kill_pll;
    assign sys_sel_eff = held.force_rc ? SRC_RC : sys_sel;
    assign brk_pulse   = brk_q;
    assign nmi_req     = pend;

    assert_brk_single_R5: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |=> !brk_pulse);

    assert_osc_off_R4: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |-> !osc_en);

    assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !irq_clear) |=> nmi_req);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        fail_evt |=> (nmi_req && brk_pulse));

endmodule

// File: rtl/cfd_guard.sv
module cfd_guard
    import cfd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       clk_mon,
    input  logic       det_en,
    input  logic       osc_ready,
    input  logic       osc_en_req,
    input  logic       pll_en_req,
    input  logic [1:0] sys_sel,
    input  logic       pll_src_ext,
    input  logic       irq_clear,
    output logic       osc_en,
    output logic       pll_en,
    output logic [1:0] sys_sel_eff,
    output logic       brk_pulse,
    output logic       nmi_req
);
    logic activity;
    logic live;
    logic starved;
    logic fail_evt;

    cfd_activity #(.SYNC_STAGES(SYNC_STAGES)) u_act (
        .clk_ref (clk_ref),
        .clk_mon (clk_mon),
        .rst     (rst),
        .activity(activity)
    );

    cfd_starve_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk_ref),
        .rst     (rst),
        .live    (live),
        .activity(activity),
        .starved (starved)
    );

    cfd_arm_fsm u_arm (
        .clk      (clk_ref),
        .rst      (rst),
        .det_en   (det_en),
        .osc_ready(osc_ready),
        .osc_on   (osc_en),
        .starved  (starved),
        .live     (live),
        .fail_evt (fail_evt)
    );

    cfd_failover u_fo (
        .clk        (clk_ref),
        .rst        (rst),
        .fail_evt   (fail_evt),
        .sys_sel    (sys_sel),
        .pll_src_ext(pll_src_ext),
        .osc_en_req (osc_en_req),
        .pll_en_req (pll_en_req),
        .irq_clear  (irq_clear),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .sys_sel_eff(sys_sel_eff),
        .brk_pulse  (brk_pulse),
        .nmi_req    (nmi_req)
    );

    assert_brk_needs_enable_R1: assert property (@(posedge clk_ref) disable iff (rst)
        brk_pulse |-> $past(det_en));

endmodule

// File: tb/test_cfd_guard.sv
module test_cfd_guard;
    localparam int TMO = 8;

    logic       clk_ref = 1'b0;
    logic       clk_mon = 1'b0;
    logic       mon_run = 1'b1;
    logic       rst = 1'b1;
    logic       det_en = 1'b0, osc_ready = 1'b0, osc_en_req = 1'b0, pll_en_req = 1'b0;
    logic [1:0] sys_sel = 2'd0;
    logic       pll_src_ext = 1'b0, irq_clear = 1'b0;
    logic       osc_en, pll_en, brk_pulse, nmi_req;
    logic [1:0] sys_sel_eff;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    cfd_guard #(.TIMEOUT_CYC(TMO)) i_cfd_guard (
        .clk_ref(clk_ref), .rst(rst), .clk_mon(clk_mon),
        .det_en(det_en), .osc_ready(osc_ready), .osc_en_req(osc_en_req),
        .pll_en_req(pll_en_req), .sys_sel(sys_sel), .pll_src_ext(pll_src_ext),
        .irq_clear(irq_clear), .osc_en(osc_en), .pll_en(pll_en),
        .sys_sel_eff(sys_sel_eff), .brk_pulse(brk_pulse), .nmi_req(nmi_req)
    );

    always #10 clk_ref = ~clk_ref;
    initial forever begin
        #15;
        if (mon_run) clk_mon = ~clk_mon;
    end

    always @(posedge clk_ref) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
    endtask

    // counts break pulses over n cycles
    task automatic count_brk(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_ref);
            if (brk_pulse) cnt++;
        end
    endtask

    task automatic park();
        @(negedge clk_ref);
        det_en = 0; osc_en_req = 0; pll_en_req = 0; sys_sel = 0;
        pll_src_ext = 0; irq_clear = 1; mon_run = 1; osc_ready = 0;
        step(4);
        irq_clear = 0;
        step(2);
    endtask

    task automatic arm(logic [1:0] sel, logic pext);
        @(negedge clk_ref);
        osc_en_req = 1; pll_en_req = 1; sys_sel = sel; pll_src_ext = pext;
        osc_ready = 1; det_en = 1;
        step(10);
    endtask

    // stops the monitored clock, waits for the pulse, returns latency and snapshots
    task automatic trip(output int lat, output logic s_osc, output logic s_pll,
                        output logic [1:0] s_sel, output logic s_nmi, output logic after);
        lat = -1; s_osc = 1; s_pll = 0; s_sel = 0; s_nmi = 0; after = 0;
        mon_run = 0;
        for (int i = 1; i <= TMO + 20; i++) begin
            @(negedge clk_ref);
            if (brk_pulse && lat < 0) begin
                lat = i; s_osc = osc_en; s_pll = pll_en; s_sel = sys_sel_eff; s_nmi = nmi_req;
                @(negedge clk_ref);
                after = brk_pulse;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1", brk_pulse, 0, "brk after reset");
        check("R1", nmi_req, 0, "nmi after reset");
        check("R1", osc_en, 0, "osc_en after reset");
    endtask

    task automatic t_disabled();
        int n;
        park(); arm(2'd1, 0);
        @(negedge clk_ref); det_en = 0;
        mon_run = 0;
        count_brk(4 * TMO, n);
        check("R1", n, 0, "pulses with det_en low");
        check("R1", nmi_req, 0, "nmi with det_en low");
    endtask

    task automatic t_wait_ready();
        int n;
        park();
        @(negedge clk_ref);
        osc_en_req = 1; sys_sel = 1; det_en = 1; osc_ready = 0;
        mon_run = 0;
        count_brk(4 * TMO, n);
        check("R2", n, 0, "pulses before oscillator ready");
        park(); arm(2'd1, 0);
        @(negedge clk_ref); osc_ready = 0;
        mon_run = 0;
        count_brk(4 * TMO, n);
        check("R2", n, 0, "pulses after ready dropped");
        check("R2", osc_en, 1, "osc_en kept after disarm");
    endtask

    task automatic t_running();
        int n;
        park(); arm(2'd1, 0);
        count_brk(300, n);
        check("R3", n, 0, "false trips with clock running");
        check("R3", nmi_req, 0, "nmi with clock running");
    endtask

    task automatic t_ext_fail();
        int lat, n; logic so, sp, sn, af; logic [1:0] ss;
        park(); arm(2'd1, 0);
        trip(lat, so, sp, ss, sn, af);
        check("R3", int'(lat >= TMO && lat <= TMO + 6), 1, "latency in window");
        check("R4", so, 0, "osc_en during break");
        check("R5", af, 0, "break width one cycle");
        check("R6", sn, 1, "nmi during break");
        check("R7", ss, 0, "mux forced to RC (sel ext)");
        check("R8", sp, 1, "pll_en untouched (sel ext)");
        count_brk(4 * TMO, n);
        check("R5", n, 0, "no second pulse while tripped");
        check("R6", nmi_req, 1, "nmi held");
        check("R7", sys_sel_eff, 0, "override held");
        @(negedge clk_ref); irq_clear = 1;
        @(negedge clk_ref); irq_clear = 0;
        check("R6", nmi_req, 0, "nmi after clear");
        check("R4", osc_en, 0, "osc still forced off");
        osc_en_req = 0;
        @(negedge clk_ref); osc_en_req = 1;
        @(negedge clk_ref);
        check("R4", osc_en, 1, "osc released after request drop");
        sys_sel = 2'd1;
        @(negedge clk_ref);
        check("R7", sys_sel_eff, 0, "override kept until RC written");
        sys_sel = 2'd0;
        @(negedge clk_ref); sys_sel = 2'd1;
        @(negedge clk_ref);
        check("R7", sys_sel_eff, 1, "override released");
        // re-arm needs det_en cycled
        mon_run = 1; det_en = 0; step(3); det_en = 1; step(10);
        trip(lat, so, sp, ss, sn, af);
        check("R5", int'(lat > 0), 1, "pulse after re-arm");
    endtask

    task automatic t_pll_fail(logic pext);
        int lat; logic so, sp, sn, af; logic [1:0] ss;
        park(); arm(2'd2, pext);
        trip(lat, so, sp, ss, sn, af);
        check("R8", sp, pext ? 0 : 1, pext ? "pll off (ext-fed)" : "pll kept (rc-fed)");
        check("R7", ss, pext ? 0 : 2, pext ? "mux forced (ext-fed pll)" : "mux kept (rc-fed pll)");
        if (pext) begin
            @(negedge clk_ref); pll_en_req = 0;
            @(negedge clk_ref); pll_en_req = 1;
            @(negedge clk_ref);
            check("R8", pll_en, 1, "pll released after request drop");
        end
    endtask

    task automatic t_rc_fail();
        int lat; logic so, sp, sn, af; logic [1:0] ss;
        park(); arm(2'd0, 1);
        trip(lat, so, sp, ss, sn, af);
        check("R7", ss, 0, "mux stays RC");
        check("R8", sp, 1, "pll kept when not system clock");
        check("R4", so, 0, "osc off on RC-sourced failure");
    endtask

    task automatic t_clear_race();
        int lat; logic so, sp, sn, af; logic [1:0] ss;
        park(); arm(2'd1, 0);
        @(negedge clk_ref); irq_clear = 1;
        trip(lat, so, sp, ss, sn, af);
        check("R9", sn, 1, "nmi set despite concurrent clear");
        check("R9", nmi_req, 0, "held clear removes flag next cycle");
        irq_clear = 0;
    endtask

    initial begin
        step(5);
        @(negedge clk_ref); rst = 0;
        step(1);
        t_reset();
        t_disabled();
        t_wait_ready();
        t_running();
        t_ext_fail();
        t_pll_fail(1'b1);
        t_pll_fail(1'b0);
        t_rc_fail();
        t_clear_race();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule